// File: doc/BRIEF.md
# Hysteretic Gain-Ratio Controller for a Switched-Capacitor Step-Down Stage

This block is the digital control for a reconfigurable switched-capacitor step-down converter under bang-bang regulation. A window comparator outside the block reports two bits once per fast clock. One bit says the output has fallen to or below the lower band edge. The other says it has risen to or above the upper band edge. From these bits the controller gates the power stage on and off. It holds its last decision while the output sits inside the band.

The power-stage cycle is a fixed number of fast-clock ticks, four by default. Within each cycle the controller drives a charge phase and a discharge phase for the switch array. A programmable gap of ticks separates the two phases, and both are low during the gap. The first time the stage is gated off, regulation counts as reached and the load enable is asserted.

The controller also counts consecutive power-stage cycles that run with the stage enabled. If that count hits a limit, it concludes the present gain ratio cannot sustain the output and steps up one level, from 1/3 to 1/2 to 2/3. The limit is seven cycles before regulation is first reached. After that, the step happens on the fifth consecutive cycle, that is, more than four.

Top module: `sc_gain_ctrl`

## Requirements
- R1: After reset the gain ratio code is 0 (1/3), the stage enable is 1, the load enable is 0 and the saturation flag is 0.
- R2: A high on below_lo_i enables the stage at the next clock. A high on above_hi_i with below_lo_i low disables it at the next clock. With both low the enable holds. With both high the stage is enabled.
- R3: The load enable rises at the clock where the stage is first disabled, and stays high until reset.
- R4: Before the load enable is set, the gain ratio steps up once the stage has run for 7 consecutive completed stage cycles.
- R5: Once the load enable is set, the gain ratio steps up on the 5th consecutive completed stage cycle with the stage enabled.
- R6: The gain ratio codes are 0 = 1/3, 1 = 1/2 and 2 = 2/3. The code only ever rises, and by one step at a time. The cycle count restarts after each step.
- R7: At code 2, an escalation leaves the code unchanged and raises esc_ignored_o for exactly one clock.
- R8: A stage cycle is SUB_TICKS fast clocks. The tick index is 0 in the first cycle after reset and advances by one per clock. phi_chg_o is high at ticks 0 to SUB_TICKS/2-GAP_TICKS-1. phi_dis_o is high over the same span offset by SUB_TICKS/2. Both are low in the gaps and whenever the stage is disabled.
- R9: The consecutive-cycle count clears whenever the stage is disabled, so a step needs a full fresh run after re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, SUB_TICKS times the stage rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| below_lo_i | input | 1 | Output at or below lower band edge |
| above_hi_i | input | 1 | Output at or above upper band edge |
| stage_en_o | output | 1 | Power-stage clock enable |
| load_en_o | output | 1 | Load enable, set at first regulation |
| gain_ratio_o | output | 2 | Selected gain ratio code |
| esc_ignored_o | output | 1 | Pulse when escalation is refused at the top ratio |
| phi_chg_o | output | 1 | Charge phase drive |
| phi_dis_o | output | 1 | Discharge phase drive |

## Verification
The first pattern holds the comparator silent from reset. This separates the seven-cycle pre-regulation limit from the post-regulation limit. It walks the ratio to the top, where the refusal pulse shows up. A second run reaches regulation early and then re-enables the stage. It times the step at the fifth cycle, which sets the post limit apart from the pre limit. A mid-run gate-off placed after two counted cycles moves the step by exactly two cycles if the count is not cleared. Driving both comparator bits high shows the priority of enable. Phase values are checked at every tick position, both while the stage is enabled and while it is gated.

// File: rtl/gr_ctrl_pkg.sv
package gr_ctrl_pkg;
  typedef enum logic [1:0] {
    GR_THIRD      = 2'd0,
    GR_HALF       = 2'd1,
    GR_TWO_THIRDS = 2'd2
  } gain_ratio_e;
endpackage

// File: rtl/sc_phase_gen.sv
module sc_phase_gen #(
  parameter int SUB_TICKS = 4,
  parameter int GAP_TICKS = 1,
  localparam int TW = (SUB_TICKS > 2) ? $clog2(SUB_TICKS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic          cyc_end_o,
  output logic          chg_o,
  output logic          dis_o
);
  localparam int HALF = SUB_TICKS / 2;
  localparam int PH   = HALF - GAP_TICKS;

  logic [TW-1:0] tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         tick_q <= '0;
    else if (tick_q == TW'(SUB_TICKS-1)) tick_q <= '0;
    else                                 tick_q <= tick_q + 1'b1;
  end

  assign cyc_end_o = (tick_q == TW'(SUB_TICKS-1));
  assign chg_o = en_i && (tick_q < TW'(PH));
  assign dis_o = en_i && (tick_q >= TW'(HALF)) && (tick_q < TW'(HALF+PH));

  initial begin
    assert (GAP_TICKS >= 1 && PH >= 1)
      else $error("phase gap parameters invalid");
  end

  // R8: a falling charge phase is followed by gap, not discharge
  assert_gap_after_chg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(chg_o) |-> !dis_o);
  assert_no_overlap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |=> !dis_o);
endmodule

// File: rtl/sc_gate_ctrl.sv
module sc_gate_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic below_i,
  input  logic above_i,
  output logic en_o,
  output logic steady_o
);
  logic en_q, en_d, steady_q;

  always_comb begin
    en_d = en_q;
    if (below_i)      en_d = 1'b1;
    else if (above_i) en_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b1;
      steady_q <= 1'b0;
    end else begin
      en_q <= en_d;
      if (en_q && !en_d) steady_q <= 1'b1;
    end
  end

  assign en_o     = en_q;
  assign steady_o = steady_q;

  assert_on_below_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    below_i |=> en_o);
  assert_off_above_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (above_i && !below_i) |=> !en_o);
  assert_load_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steady_o |=> steady_o);
  assert_load_on_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(steady_o) |-> !en_o);
endmodule

// File: rtl/sc_gr_escalator.sv
module sc_gr_escalator
  import gr_ctrl_pkg::*;
#(
  parameter int PRE_LIMIT   = 7,
  parameter int POST_EXCESS = 4,
  localparam int MAXL = (PRE_LIMIT > POST_EXCESS + 1) ? PRE_LIMIT : POST_EXCESS + 1,
  localparam int CW   = $clog2(MAXL + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        cyc_end_i,
  input  logic        steady_i,
  output gain_ratio_e gr_o,
  output logic        ign_o
);
  gain_ratio_e gr_q;
  logic [CW-1:0] cnt_q, cnt_inc, limit;
  logic ign_q, hit;

  assign cnt_inc = cnt_q + 1'b1;
  assign limit   = steady_i ? CW'(POST_EXCESS + 1) : CW'(PRE_LIMIT);
  assign hit     = en_i && cyc_end_i && (cnt_inc == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      gr_q  <= GR_THIRD;
      ign_q <= 1'b0;
    end else begin
      ign_q <= 1'b0;
      if (!en_i)          cnt_q <= '0;
      else if (hit)       cnt_q <= '0;
      else if (cyc_end_i) cnt_q <= cnt_inc;
      if (hit) begin
        case (gr_q)
          GR_THIRD: gr_q <= GR_HALF;
          GR_HALF:  gr_q <= GR_TWO_THIRDS;
          default:  ign_q <= 1'b1;
        endcase
      end
    end
  end

  assign gr_o  = gr_q;
  assign ign_o = ign_q;

  assert_gr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gr_q) |-> (gr_q == gain_ratio_e'($past(gr_q) + 2'd1)));
  assert_gr_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gr_q != 2'd3);
  assert_cnt_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
  assert_sat_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ign_q |-> gr_q == GR_TWO_THIRDS && $stable(gr_q));
  assert_ign_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ign_q |=> !ign_q);
endmodule

// File: rtl/sc_gain_ctrl.sv
module sc_gain_ctrl
  import gr_ctrl_pkg::*;
#(
  parameter int SUB_TICKS   = 4,
  parameter int GAP_TICKS   = 1,
  parameter int PRE_LIMIT   = 7,
  parameter int POST_EXCESS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       below_lo_i,
  input  logic       above_hi_i,
  output logic       stage_en_o,
  output logic       load_en_o,
  output logic [1:0] gain_ratio_o,
  output logic       esc_ignored_o,
  output logic       phi_chg_o,
  output logic       phi_dis_o
);
  logic en, steady, cyc_end;
  gain_ratio_e gr;

  sc_gate_ctrl u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .below_i(below_lo_i), .above_i(above_hi_i),
    .en_o(en), .steady_o(steady)
  );

  sc_phase_gen #(.SUB_TICKS(SUB_TICKS), .GAP_TICKS(GAP_TICKS)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en),
    .cyc_end_o(cyc_end), .chg_o(phi_chg_o), .dis_o(phi_dis_o)
  );

  sc_gr_escalator #(.PRE_LIMIT(PRE_LIMIT), .POST_EXCESS(POST_EXCESS)) u_esc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .cyc_end_i(cyc_end),
    .steady_i(steady), .gr_o(gr), .ign_o(esc_ignored_o)
  );

  assign stage_en_o   = en;
  assign load_en_o    = steady;
  assign gain_ratio_o = gr;

  assert_phases_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stage_en_o |-> !phi_chg_o && !phi_dis_o);
endmodule

// File: tb/sc_gain_ctrl_bench.sv
module sc_gain_ctrl_bench;
  typedef struct {
    int         cyc;
    logic [6:0] vec;
    string      req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic below = 1'b0, above = 1'b0;
  logic stage_en, load_en, ign, chg, dis;
  logic [1:0] gr;
  int cyc = 0;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #10 clk = ~clk;

  sc_gain_ctrl u_sc_gain_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .below_lo_i(below), .above_hi_i(above),
    .stage_en_o(stage_en), .load_en_o(load_en), .gain_ratio_o(gr),
    .esc_ignored_o(ign), .phi_chg_o(chg), .phi_dis_o(dis)
  );

  initial forever begin
    @(posedge clk);
    if (!rst_n) cyc = 0; else cyc = cyc + 1;
  end

  // vec = {gr, en, load, ign, chg, dis}; phases follow from R8 with 4 ticks, gap 1
  task automatic expect_at(int c, logic [1:0] g, logic e, logic l, logic i, string r);
    exp_t it;
    it.cyc = c;
    it.vec = {g, e, l, i, e && (c % 4 == 0), e && (c % 4 == 2)};
    it.req = r;
    q.push_back(it);
  endtask

  task automatic after_cyc(int n);
    while (cyc < n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; below = 1'b0; above = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // monitor: pops expected items as the design reaches their cycle
  initial forever begin
    @(negedge clk);
    #1;
    while (rst_n && q.size() > 0 && q[0].cyc == cyc) begin
      exp_t it;
      logic [6:0] got;
      it = q.pop_front();
      got = {gr, stage_en, load_en, ign, chg, dis};
      n_checks++;
      if (got !== it.vec) begin
        n_fail++;
        $display("FAIL %s cyc %0d: got %b expected %b (gr,en,load,ign,chg,dis)",
                 it.req, it.cyc, got, it.vec);
      end
    end
  end

  initial begin
    // scenario A: comparator silent
    do_reset();
    expect_at(0,  2'd0, 1, 0, 0, "R1");
    expect_at(1,  2'd0, 1, 0, 0, "R8");
    expect_at(2,  2'd0, 1, 0, 0, "R8");
    expect_at(3,  2'd0, 1, 0, 0, "R8");
    expect_at(27, 2'd0, 1, 0, 0, "R4");
    expect_at(28, 2'd1, 1, 0, 0, "R4");
    expect_at(55, 2'd1, 1, 0, 0, "R6");
    expect_at(56, 2'd2, 1, 0, 0, "R6");
    expect_at(84, 2'd2, 1, 0, 1, "R7");
    expect_at(85, 2'd2, 1, 0, 0, "R7");
    expect_at(91, 2'd2, 0, 1, 0, "R3");
    expect_at(92, 2'd2, 0, 1, 0, "R8");
    after_cyc(90); above = 1'b1;
    after_cyc(91); above = 1'b0;
    after_cyc(94);
    // scenario B: early regulation
    do_reset();
    expect_at(0,  2'd0, 1, 0, 0, "R1");
    expect_at(3,  2'd0, 0, 1, 0, "R3");
    expect_at(10, 2'd0, 0, 1, 0, "R2");
    expect_at(11, 2'd0, 1, 1, 0, "R2");
    expect_at(27, 2'd0, 1, 1, 0, "R5");
    expect_at(28, 2'd1, 1, 1, 0, "R5");
    expect_at(37, 2'd1, 0, 1, 0, "R9");
    expect_at(59, 2'd1, 1, 1, 0, "R9");
    expect_at(60, 2'd2, 1, 1, 0, "R9");
    expect_at(63, 2'd2, 1, 1, 0, "R2");
    expect_at(64, 2'd2, 0, 1, 0, "R2");
    after_cyc(2);  above = 1'b1;
    after_cyc(3);  above = 1'b0;
    after_cyc(10); below = 1'b1;
    after_cyc(11); below = 1'b0;
    after_cyc(36); above = 1'b1;
    after_cyc(37); above = 1'b0;
    after_cyc(40); below = 1'b1;
    after_cyc(41); below = 1'b0;
    after_cyc(62); below = 1'b1; above = 1'b1;
    after_cyc(63); below = 1'b0;
    after_cyc(64); above = 1'b0;
    after_cyc(67);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R1 unchecked items: got %0d expected 0", q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule